// File: doc/BRIEF.md
# Banked Memory Contention Controller

This block works out, for each CPU memory or I/O cycle in a banked 128K memory map, whether the cycle clashes with the video fetches and how many wait T-states the CPU must take. A request carries the CPU address and the number of the RAM bank paged into the top 16K of the map. The block samples its own frame T-state counter in the cycle it accepts the request. One clock later it returns a contended flag and a wait count from 0 to 6.

The frame T-state counter is part of the block. It advances once per clock, wraps at the end of the frame and drives the frame interrupt, which is high for the first T-states of every frame. Clock gating of the CPU, I/O port decoding beyond the address test, and the pixel path lie outside the block.

Requests and responses use valid/ready handshakes. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The response stays in its output register, unchanged, until it is taken on an edge where `rsp_valid` and `rsp_ready` are both high. `req_ready` is high while the output register is empty or is being drained in the same cycle. A stalled response therefore holds back new requests, so a response is never dropped or overwritten.

Top module: `mem_contention_ctrl`

## Requirements
- R1: An address whose bits 15:14 are 01 (0x4000 to 0x7FFF) is reported as contended whatever the bank.
- R2: An address whose bits 15:14 are 11 is contended only when the paged bank is odd (1, 3, 5 or 7, bank bit 0 set). Addresses with bits 15:14 equal to 00 or 10 are never contended.
- R3: `tstate` counts 0, 1, 2, … and advances by one every clock. It goes from 70907 back to 0, so the frame is 70908 T-states long, and it is 0 during a synchronous reset.
- R4: Wait states are inserted only in the window of T-states 14361 to 58136 inclusive. That is 192 lines of 228 T-states, starting at 14361. Outside the window the wait count is 0.
- R5: Inside the window, the line position is (T-state − 14361) mod 228. Only positions 0 to 127 take waits; positions 128 to 227 give 0.
- R6: At a delaying position, the wait count is set by the position mod 8. The values for 0, 1, 2, 3, 4, 5, 6 and 7 are 6, 5, 4, 3, 2, 1, 0 and 0.
- R7: A request to an address that is not contended returns a wait count of 0.
- R8: `frame_irq` is high exactly while `tstate` is 0 to 35, which is 36 T-states at the start of each frame.
- R9: A response appears one clock after its request is accepted. It is computed from the `tstate` value present in the accepting cycle.
- R10: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged.
- R11: During reset `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 16 | CPU address of the cycle |
| req_bank | input | 3 | RAM bank paged into the top 16K |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_contended | output | 1 | Address lies in contended memory |
| rsp_wait | output | 3 | Wait T-states to insert, 0 to 6 |
| tstate | output | 17 | Current frame T-state |
| frame_irq | output | 1 | Frame interrupt, high for T-states 0 to 35 |

## Verification
The bench drives requests at the window's first and last T-states, at line positions 127 and 128, and across the frame wrap and the end of the interrupt.
- If the window start or the line phase were off by one, every wait would be shifted by a single position at those edges.
- If the counter wrapped at the wrong value, the whole pattern would drift in the second frame the bench covers.

Random bank numbers and all four address regions are mixed together.
- If the design tested the bank the wrong way, even banks would show contention in the top region.
- If the design ignored the bank, odd banks would show no contention there.

Random `rsp_ready` stalls check that a held response does not change and that `req_ready` drops. A design that overwrote the output register would lose or corrupt a response.

// File: rtl/memc_pkg.sv
package memc_pkg;

  typedef enum logic [1:0] {
    RGN_LOW    = 2'b00,
    RGN_SCREEN = 2'b01,
    RGN_MID    = 2'b10,
    RGN_PAGED  = 2'b11
  } mem_region_e;

  localparam int unsigned DEF_FRAME_LEN  = 70908;
  localparam int unsigned DEF_LINE_LEN   = 228;
  localparam int unsigned DEF_CONT_START = 14361;
  localparam int unsigned DEF_CONT_LINES = 192;
  localparam int unsigned DEF_CONT_SPAN  = 128;
  localparam int unsigned DEF_IRQ_LEN    = 36;
  localparam int unsigned DEF_MAX_WAIT   = 6;
  localparam int unsigned DEF_PERIOD     = 8;

endpackage

// File: rtl/cont_frame_timer.sv
module cont_frame_timer #(
  parameter int unsigned FRAME_LEN  = memc_pkg::DEF_FRAME_LEN,
  parameter int unsigned LINE_LEN   = memc_pkg::DEF_LINE_LEN,
  parameter int unsigned CONT_START = memc_pkg::DEF_CONT_START,
  parameter int unsigned CONT_LINES = memc_pkg::DEF_CONT_LINES,
  parameter int unsigned IRQ_LEN    = memc_pkg::DEF_IRQ_LEN,
  parameter int unsigned TS_W       = $clog2(FRAME_LEN),
  parameter int unsigned COL_W      = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TS_W-1:0]  tstate,
  output logic [COL_W-1:0] line_pos,
  output logic             in_window,
  output logic             irq
);

  localparam int unsigned CONT_END    = CONT_START + CONT_LINES * LINE_LEN;
  localparam int unsigned POS_AT_ZERO = (LINE_LEN - (CONT_START % LINE_LEN)) % LINE_LEN;

  localparam logic [TS_W-1:0]  T_LAST   = TS_W'(FRAME_LEN - 1);
  localparam logic [TS_W-1:0]  T_START  = TS_W'(CONT_START);
  localparam logic [TS_W-1:0]  T_END    = TS_W'(CONT_END);
  localparam logic [TS_W-1:0]  T_IRQ    = TS_W'(IRQ_LEN);
  localparam logic [COL_W-1:0] POS_LAST = COL_W'(LINE_LEN - 1);
  localparam logic [COL_W-1:0] POS_INIT = COL_W'(POS_AT_ZERO);

  logic at_frame_end;

  assign at_frame_end = (tstate == T_LAST);

  // frame T-state counter
  always_ff @(posedge clk) begin
    if (rst) begin
      tstate <= '0;
    end else if (at_frame_end) begin
      tstate <= '0;
    end else begin
      tstate <= tstate + TS_W'(1);
    end
  end

  // line position counter, phased so that it reads 0 at the window start
  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos <= POS_INIT;
    end else if (at_frame_end) begin
      line_pos <= POS_INIT;
    end else if (line_pos == POS_LAST) begin
      line_pos <= '0;
    end else begin
      line_pos <= line_pos + COL_W'(1);
    end
  end

  assign in_window = (tstate >= T_START) && (tstate < T_END);
  assign irq       = (tstate < T_IRQ);

  AST_TS_RANGE: assert property (@(posedge clk) disable iff (rst)
    tstate <= T_LAST);  // R3
  AST_TS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tstate == T_LAST) |=> (tstate == '0));  // R3
  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    (tstate != T_LAST) |=> (tstate == $past(tstate) + TS_W'(1)));  // R3
  AST_POS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (tstate == T_START) |-> (line_pos == '0));  // R5
  AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (tstate == '0));  // R8

endmodule

// File: rtl/cont_addr_decode.sv
module cont_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned NUM_BANKS = 1 << BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              contended
);
  import memc_pkg::*;

  mem_region_e       region;
  logic [NUM_BANKS-1:0] bank_slow;

  // banks sharing memory with the video fetches: the odd-numbered ones
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_slow[b] = ((b % 2) == 1);
  end

  assign region = mem_region_e'(addr[ADDR_W-1 -: 2]);

  always_comb begin
    unique case (region)
      RGN_SCREEN: contended = 1'b1;
      RGN_PAGED:  contended = bank_slow[bank];
      default:    contended = 1'b0;
    endcase
  end

endmodule

// File: rtl/cont_delay_lut.sv
module cont_delay_lut #(
  parameter int unsigned CONT_SPAN = memc_pkg::DEF_CONT_SPAN,
  parameter int unsigned MAX_WAIT  = memc_pkg::DEF_MAX_WAIT,
  parameter int unsigned PERIOD    = memc_pkg::DEF_PERIOD,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned WAIT_W    = $clog2(MAX_WAIT + 1)
) (
  input  logic [COL_W-1:0]  line_pos,
  input  logic              in_window,
  output logic [WAIT_W-1:0] wait_cnt
);

  localparam int unsigned PH_W = $clog2(PERIOD);
  localparam logic [COL_W-1:0]  SPAN_END = COL_W'(CONT_SPAN);
  localparam logic [WAIT_W-1:0] W_MAX    = WAIT_W'(MAX_WAIT);

  logic [PH_W-1:0] phase;
  logic            active;

  assign phase  = line_pos[PH_W-1:0];
  assign active = in_window && (line_pos < SPAN_END);

  always_comb begin
    if (!active) begin
      wait_cnt = '0;
    end else if (WAIT_W'(phase) < W_MAX) begin
      wait_cnt = W_MAX - WAIT_W'(phase);
    end else begin
      wait_cnt = '0;
    end
  end

endmodule

// File: rtl/mem_contention_ctrl.sv
module mem_contention_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BANK_W     = 3,
  parameter int unsigned FRAME_LEN  = memc_pkg::DEF_FRAME_LEN,
  parameter int unsigned LINE_LEN   = memc_pkg::DEF_LINE_LEN,
  parameter int unsigned CONT_START = memc_pkg::DEF_CONT_START,
  parameter int unsigned CONT_LINES = memc_pkg::DEF_CONT_LINES,
  parameter int unsigned CONT_SPAN  = memc_pkg::DEF_CONT_SPAN,
  parameter int unsigned IRQ_LEN    = memc_pkg::DEF_IRQ_LEN,
  parameter int unsigned MAX_WAIT   = memc_pkg::DEF_MAX_WAIT,
  parameter int unsigned PERIOD     = memc_pkg::DEF_PERIOD,
  parameter int unsigned TS_W       = $clog2(FRAME_LEN),
  parameter int unsigned WAIT_W     = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_contended,
  output logic [WAIT_W-1:0] rsp_wait,
  output logic [TS_W-1:0]   tstate,
  output logic              frame_irq
);

  localparam int unsigned COL_W = $clog2(LINE_LEN);
  localparam logic [WAIT_W-1:0] W_MAX = WAIT_W'(MAX_WAIT);

  logic [COL_W-1:0]  line_pos;
  logic              in_window;
  logic              addr_slow;
  logic [WAIT_W-1:0] slot_wait;
  logic              take_req;

  cont_frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .LINE_LEN  (LINE_LEN),
    .CONT_START(CONT_START),
    .CONT_LINES(CONT_LINES),
    .IRQ_LEN   (IRQ_LEN),
    .TS_W      (TS_W),
    .COL_W     (COL_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tstate   (tstate),
    .line_pos (line_pos),
    .in_window(in_window),
    .irq      (frame_irq)
  );

  cont_addr_decode #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W)
  ) u_decode (
    .addr     (req_addr),
    .bank     (req_bank),
    .contended(addr_slow)
  );

  cont_delay_lut #(
    .CONT_SPAN(CONT_SPAN),
    .MAX_WAIT (MAX_WAIT),
    .PERIOD   (PERIOD),
    .COL_W    (COL_W),
    .WAIT_W   (WAIT_W)
  ) u_delay (
    .line_pos (line_pos),
    .in_window(in_window),
    .wait_cnt (slot_wait)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take_req  = req_valid && req_ready;

  // single output register; refilled only when empty or being drained
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_contended <= 1'b0;
      rsp_wait      <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (take_req) begin
        rsp_contended <= addr_slow;
        rsp_wait      <= addr_slow ? slot_wait : '0;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_wait) && $stable(rsp_contended)));  // R10
  AST_FREE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_contended) |-> (rsp_wait == '0));  // R7
  AST_WAIT_MAX: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_wait <= W_MAX));  // R6
  AST_SCREEN_SLOW: assert property (@(posedge clk) disable iff (rst)
    (take_req && (req_addr[ADDR_W-1 -: 2] == 2'b01)) |=> (rsp_valid && rsp_contended));  // R1
  AST_LOWER_FREE: assert property (@(posedge clk) disable iff (rst)
    (take_req && !req_addr[ADDR_W-2]) |=> (rsp_valid && !rsp_contended));  // R2
  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (take_req && !in_window) |=> (rsp_wait == '0));  // R4
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !rsp_valid);  // R11

endmodule

// File: tb/tb_mem_contention_ctrl.sv
`timescale 1ns/1ps
module tb_mem_contention_ctrl;

  localparam int FRAME  = 70908;
  localparam int LINE   = 228;
  localparam int WSTART = 14361;
  localparam int WEND   = 14361 + 192 * 228;
  localparam int ITERS  = 76000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_bank = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_contended;
  logic [2:0]  rsp_wait;
  logic [16:0] tstate;
  logic        frame_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_t;
  bit exp_pend;
  bit exp_cont;
  int exp_wait_v;
  string exp_tag;

  always #5 clk = ~clk;

  mem_contention_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bank(req_bank),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_contended(rsp_contended), .rsp_wait(rsp_wait),
    .tstate(tstate), .frame_irq(frame_irq)
  );

  function automatic bit ref_cont(input logic [15:0] a, input logic [2:0] b);
    return (a[15:14] == 2'b01) || (a[15:14] == 2'b11 && b[0]);
  endfunction

  function automatic int ref_wait(input logic [15:0] a, input logic [2:0] b, input int t);
    int pos;
    int ph;
    if (!ref_cont(a, b)) return 0;
    if (t < WSTART || t >= WEND) return 0;
    pos = (t - WSTART) % LINE;
    if (pos >= 128) return 0;
    ph = pos % 8;
    return (ph < 6) ? 6 - ph : 0;
  endfunction

  function automatic string wait_tag(input logic [15:0] a, input logic [2:0] b, input int t);
    if (!ref_cont(a, b)) return "R7";
    if (t < WSTART || t >= WEND) return "R4";
    if (((t - WSTART) % LINE) >= 128) return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, exp_t);
    end
  endtask

  function automatic bit is_corner(input int t);
    return t == WSTART - 1 || t == WSTART || t == WSTART + 1 ||
           t == WSTART + 127 || t == WSTART + 128 || t == WSTART + LINE ||
           t == WEND - 1 || t == WEND || t == FRAME - 1 || t == 0 ||
           t == 35 || t == 36;
  endfunction

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 / R3 / R8 reset state
    check(rsp_valid == 1'b0, "R11", rsp_valid, 0);
    check(tstate == '0, "R3", tstate, 0);
    check(frame_irq == 1'b1, "R8", frame_irq, 1);
    rst = 1'b0;
    exp_t = 0;
    exp_pend = 1'b0;
    for (int i = 0; i < ITERS; i++) begin
      // drive this cycle
      if (is_corner(exp_t)) begin
        req_valid = 1'b1;
        req_addr  = 16'h4000 | 16'($urandom_range(0, 16'h3fff));
        req_bank  = 3'($urandom);
        rsp_ready = 1'b1;
      end else begin
        req_valid = ($urandom_range(0, 9) != 0);
        req_addr  = 16'($urandom);
        req_bank  = 3'($urandom);
        rsp_ready = ($urandom_range(0, 3) != 0);
      end
      #1;
      // R10 ready rule
      check(req_ready == (!exp_pend || rsp_ready), "R10", req_ready, (!exp_pend || rsp_ready));
      if (req_valid && (!exp_pend || rsp_ready)) begin
        exp_pend   = 1'b1;
        exp_cont   = ref_cont(req_addr, req_bank);
        exp_wait_v = ref_wait(req_addr, req_bank, exp_t);
        exp_tag    = wait_tag(req_addr, req_bank, exp_t);
      end else if (rsp_ready) begin
        exp_pend = 1'b0;
      end
      exp_t = (exp_t == FRAME - 1) ? 0 : exp_t + 1;
      @(negedge clk);
      // R9 response timing and content; R10 held fields compared too
      check(rsp_valid == exp_pend, "R9", rsp_valid, exp_pend);
      if (exp_pend && rsp_valid) begin
        check(rsp_contended == exp_cont,
              (req_addr[15:14] == 2'b01) ? "R1" : "R2", rsp_contended, exp_cont);
        check(int'(rsp_wait) == exp_wait_v, exp_tag, rsp_wait, exp_wait_v);
      end
      check(int'(tstate) == exp_t, "R3", tstate, exp_t);
      check(frame_irq == (exp_t < 36), "R8", frame_irq, (exp_t < 36));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule